// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block stands between several requesting processors and one shared single-port memory. Each requester issues one request at a time over a valid/ready handshake. The request is a plain read or write, or one of several indivisible operations: test-and-set, test-and-exchange, and a load-reserve / store-conditional pair. A round-robin arbiter picks one requester and gives it the memory port. The requester keeps the port through the read, the optional write-back and the return of its response, so no other requester can reach memory in the middle of a read-modify-write.

Each requester owns one reservation register. A load-reserve fills it. A committed write to the reserved address clears it, whichever requester makes that write. Because of this, a store-conditional can fail even though no lock was ever held. The block keeps no wait list. A requester whose lock attempt returns a non-zero value simply issues the request again later.

Operation codes on `req_op` are: 0 read, 1 write, 2 test-and-set, 3 test-and-exchange, 4 load-reserve, 5 store-conditional. Codes 6 and 7 behave as a read.

Top module: `atomic_mem_unit`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` and `resp_valid` are all zero, every memory word reads as zero, and every reservation is cleared.
- R2: A read (op 0) returns the addressed word. A write (op 1) stores `req_wdata` and returns the word's previous value.
- R3: Test-and-set (op 2) returns the old word. It writes `req_wdata` only when the old word is zero; otherwise memory is unchanged.
- R4: Test-and-exchange (op 3) returns the old word. It writes `req_wdata` only when the requester's `req_arg` is zero; otherwise memory is unchanged.
- R5: Load-reserve (op 4) returns the word and records its address in the requester's reservation. A later store-conditional (op 5) to the same address with the reservation still held writes `req_wdata`, returns 1, and clears that reservation. Any number of other operations may come in between.
- R6: A store-conditional with no held reservation, or to an address other than the reserved one, returns 0 and leaves memory unchanged.
- R7: A committed write to a reserved address clears every reservation on that address. This covers plain writes, successful test-and-set, test-and-exchange and store-conditional, from any requester. Writes to other addresses leave a reservation intact.
- R8: At most one `req_ready` bit is high in any cycle, and only for a requester whose `req_valid` is high. No request is accepted while a response is pending.
- R9: The arbiter is round-robin. When several requesters are valid, the grant goes to the first valid index above the last granted one, wrapping around. After reset, index 0 has first priority.
- R10: The response appears on `resp_valid` as a single bit for the accepted requester, two cycles after the accepting edge. `resp_valid` and `resp_data` stay stable until `resp_ready` for that requester is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Per-requester request valid |
| req_ready | output | N_REQ | Per-requester request accepted this cycle |
| req_op | input | 3*N_REQ | Operation code per requester |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata | input | DATA_W*N_REQ | Value to store per requester |
| req_arg | input | DATA_W*N_REQ | Test operand for test-and-exchange |
| resp_valid | output | N_REQ | Response valid, one bit per requester |
| resp_ready | input | N_REQ | Response taken, one bit per requester |
| resp_data | output | DATA_W | Response value for the requester flagged on resp_valid |

## Verification
The bench tries to lock a word that is already held. A unit that wrote regardless of the old value would let a second owner overwrite the lock. It fails a store-conditional after another requester's write to the reserved word, and also after a successful test-and-exchange there. A unit that cleared reservations only on plain writes, or only for the writer itself, would wrongly report success. It reuses a spent reservation, aims a conditional store at an unreserved address, and resets in the middle of a reservation, so a reservation that leaks would show up as a stray 1. It also holds a response back while a competitor waits and checks the order of grants with several requesters contending. A unit that dropped the lock early or kept a fixed priority would let the competitor in or grant out of turn.

// File: rtl/amu_pkg.sv
// Shared types for the atomic memory unit: operation codes and control states.
// Assumes a 3-bit operation field; unlisted codes are treated as plain reads.
package amu_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_TAS   = 3'd2,
        OP_TXCHG = 3'd3,
        OP_LR    = 3'd4,
        OP_SC    = 3'd5
    } amu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } amu_state_e;
endpackage

// File: rtl/amu_rr_arbiter.sv
// Round-robin arbiter: one-hot grant to the first requesting index above the
// last accepted one, wrapping. Assumes N >= 2; pointer moves only on advance.
module amu_rr_arbiter #(
    parameter int N = 3,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;

    // Search upward from the slot after the last winner.
    always_comb begin
        logic found;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                grant_idx  = IW'(idx);
                found      = 1'b1;
            end
        end
    end

    // Remember the winner once its request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= IW'(N - 1);
        else if (advance) last_q <= grant_idx;
    end
endmodule

// File: rtl/amu_mem.sv
// Single-port word memory with registered read data. Cleared on reset.
// Assumes a read and a write never share a cycle; read data follows the address by one cycle.
module amu_mem #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    // Clear, write, or register the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            rdata <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end else begin
            rdata <= words[addr];
        end
    end
endmodule

// File: rtl/amu_resv.sv
// Reservation file: one address and valid flag per requester. Committed writes
// knock out every matching reservation; a set takes priority over clears.
module amu_resv #(
    parameter int N  = 3,
    parameter int AW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          own_clr,
    input  logic [IW-1:0] own_idx,
    input  logic [AW-1:0] own_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output logic          own_hit
);
    logic [N-1:0]  held_q;
    logic [AW-1:0] addr_q [N];

    // Does the current requester still hold a reservation on this address?
    assign own_hit = held_q[own_idx] && (addr_q[own_idx] == own_addr);

    // Update each reservation slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            for (int i = 0; i < N; i++) addr_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && held_q[i] && addr_q[i] == wr_addr) held_q[i] <= 1'b0;
                if (own_clr && own_idx == IW'(i))               held_q[i] <= 1'b0;
                if (set_en && own_idx == IW'(i)) begin
                    held_q[i] <= 1'b1;
                    addr_q[i] <= own_addr;
                end
            end
        end
    end
endmodule

// File: rtl/atomic_mem_unit.sv
// Atomic memory unit top. It grants one requester the memory port, reads in the
// accept cycle, decides and writes back in EXEC, then holds the response until it
// is taken. The port stays locked for that whole span.
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int N_REQ  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         req_valid,
    output logic [N_REQ-1:0]         req_ready,
    input  logic [3*N_REQ-1:0]       req_op,
    input  logic [ADDR_W*N_REQ-1:0]  req_addr,
    input  logic [DATA_W*N_REQ-1:0]  req_wdata,
    input  logic [DATA_W*N_REQ-1:0]  req_arg,
    output logic [N_REQ-1:0]         resp_valid,
    input  logic [N_REQ-1:0]         resp_ready,
    output logic [DATA_W-1:0]        resp_data
);
    localparam int IW = $clog2(N_REQ);

    amu_state_e          state_q;
    logic [IW-1:0]       cur_idx_q;
    logic [2:0]          cur_op_q;
    logic [ADDR_W-1:0]   cur_addr_q;
    logic [DATA_W-1:0]   cur_wdata_q, cur_arg_q, resp_q;

    logic [N_REQ-1:0]    grant;
    logic [IW-1:0]       grant_idx;
    logic                accept, mem_we, resv_hit, do_write;
    logic [ADDR_W-1:0]   mem_addr;
    logic [DATA_W-1:0]   mem_rdata, result;

    amu_rr_arbiter #(.N(N_REQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid), .advance(accept),
        .grant(grant), .grant_idx(grant_idx)
    );

    // Ready only while idle and out of reset.
    assign req_ready = (state_q == ST_IDLE && rst_n) ? grant : '0;
    assign accept    = |req_ready;

    // The port address comes from the winner when idle, else from the latched request.
    assign mem_addr = (state_q == ST_IDLE) ? req_addr[grant_idx*ADDR_W +: ADDR_W] : cur_addr_q;
    assign mem_we   = (state_q == ST_EXEC) && do_write;

    amu_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
        .wdata(cur_wdata_q), .rdata(mem_rdata)
    );

    amu_resv #(.N(N_REQ), .AW(ADDR_W)) u_resv (
        .clk(clk), .rst_n(rst_n),
        .set_en((state_q == ST_EXEC) && cur_op_q == OP_LR),
        .own_clr(mem_we && cur_op_q == OP_SC),
        .own_idx(cur_idx_q), .own_addr(cur_addr_q),
        .wr_en(mem_we), .wr_addr(cur_addr_q),
        .own_hit(resv_hit)
    );

    // Decide whether the operation writes, and what it returns.
    always_comb begin
        do_write = 1'b0;
        result   = mem_rdata;
        case (cur_op_q)
            OP_WRITE: do_write = 1'b1;
            OP_TAS:   do_write = (mem_rdata == '0);
            OP_TXCHG: do_write = (cur_arg_q == '0);
            OP_SC: begin
                do_write = resv_hit;
                result   = resv_hit ? DATA_W'(1) : '0;
            end
            default:  do_write = 1'b0;
        endcase
    end

    // Sequence accept -> execute -> respond, and latch the request and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_idx_q   <= '0;
            cur_op_q    <= '0;
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            cur_arg_q   <= '0;
            resp_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q     <= ST_EXEC;
                    cur_idx_q   <= grant_idx;
                    cur_op_q    <= req_op[grant_idx*3 +: 3];
                    cur_addr_q  <= req_addr[grant_idx*ADDR_W +: ADDR_W];
                    cur_wdata_q <= req_wdata[grant_idx*DATA_W +: DATA_W];
                    cur_arg_q   <= req_arg[grant_idx*DATA_W +: DATA_W];
                end
                ST_EXEC: begin
                    state_q <= ST_RESP;
                    resp_q  <= result;
                end
                ST_RESP: if (resp_ready[cur_idx_q]) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = (state_q == ST_RESP) ? (N_REQ'(1) << cur_idx_q) : '0;
    assign resp_data  = resp_q;
endmodule

// File: rtl/amu_checker.sv
// Protocol checker for the atomic memory unit, bound to every instance of the top.
// Checks handshake exclusivity, the port lock, response timing and response hold.
module amu_checker #(
    parameter int N_REQ  = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_REQ-1:0]  req_valid,
    input logic [N_REQ-1:0]  req_ready,
    input logic [N_REQ-1:0]  resp_valid,
    input logic [N_REQ-1:0]  resp_ready,
    input logic [DATA_W-1:0] resp_data
);
    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

    assert_port_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|resp_valid) |-> (req_ready == '0));

    assert_resp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |-> ##2 (resp_valid == $past(req_ready, 2)));

    assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((resp_valid & ~resp_ready) != '0) |=> ($stable(resp_valid) && $stable(resp_data)));

    assert_resp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid));
endmodule

bind atomic_mem_unit amu_checker #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_amu_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data)
);

// File: tb/tb_atomic_mem_unit.sv
`timescale 1ns/1ps
module tb_atomic_mem_unit;
    localparam int N = 3;
    localparam int AW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    v, rr;
    logic [2:0]      op_a [N];
    logic [AW-1:0]   ad_a [N];
    logic [DW-1:0]   wd_a [N], ar_a [N];
    logic [N-1:0]    req_ready, resp_valid;
    logic [3*N-1:0]  req_op;
    logic [AW*N-1:0] req_addr;
    logic [DW*N-1:0] req_wdata, req_arg;
    logic [DW-1:0]   resp_data;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_op[i*3 +: 3]       = op_a[i];
            req_addr[i*AW +: AW]   = ad_a[i];
            req_wdata[i*DW +: DW]  = wd_a[i];
            req_arg[i*DW +: DW]    = ar_a[i];
        end
    end

    atomic_mem_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_arg(req_arg),
        .resp_valid(resp_valid), .resp_ready(rr), .resp_data(resp_data)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full transaction for requester i; hold = cycles to delay resp_ready.
    task automatic xact(input int i, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] arg,
                        input int hold, output logic [DW-1:0] rd);
        @(negedge clk);
        v[i] = 1'b1; op_a[i] = op; ad_a[i] = a; wd_a[i] = wd; ar_a[i] = arg;
        #1;
        while (!req_ready[i]) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        v[i] = 1'b0;
        chk(resp_valid[i] == 1'b0, "R10 response too early", DW'(resp_valid[i]), 16'h0);
        @(negedge clk);
        chk(resp_valid[i] == 1'b1, "R10 response two cycles after accept", DW'(resp_valid[i]), 16'h1);
        rd = resp_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(resp_valid[i] && resp_data == rd, "R10 response held", resp_data, rd);
            chk(req_ready == '0, "R8 no accept while response pending", DW'(req_ready), 16'h0);
        end
        rr[i] = 1'b1;
        @(negedge clk);
        rr[i] = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]    who;
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] arg;
        logic [DW-1:0] exp;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 4'h3, 16'h0000, 16'h0, 16'h0000, 4'd1}, // R1 cleared memory
        '{2'd0, 3'd1, 4'h3, 16'h1234, 16'h0, 16'h0000, 4'd2}, // R2 write returns old
        '{2'd1, 3'd0, 4'h3, 16'h0000, 16'h0, 16'h1234, 4'd2}, // R2 read back
        '{2'd1, 3'd2, 4'h5, 16'h0007, 16'h0, 16'h0000, 4'd3}, // R3 lock free, take it
        '{2'd2, 3'd2, 4'h5, 16'h0009, 16'h0, 16'h0007, 4'd3}, // R3 lock held
        '{2'd0, 3'd0, 4'h5, 16'h0000, 16'h0, 16'h0007, 4'd3}, // R3 unchanged
        '{2'd1, 3'd3, 4'h6, 16'h00AA, 16'h0, 16'h0000, 4'd4}, // R4 operand zero swaps
        '{2'd2, 3'd3, 4'h6, 16'h00BB, 16'h1, 16'h00AA, 4'd4}, // R4 operand nonzero
        '{2'd0, 3'd0, 4'h6, 16'h0000, 16'h0, 16'h00AA, 4'd4}, // R4 unchanged
        '{2'd0, 3'd4, 4'h3, 16'h0000, 16'h0, 16'h1234, 4'd5}, // R5 reserve
        '{2'd1, 3'd0, 4'h4, 16'h0000, 16'h0, 16'h0000, 4'd5}, // R5 unrelated op between
        '{2'd0, 3'd5, 4'h3, 16'h0055, 16'h0, 16'h0001, 4'd5}, // R5 store succeeds
        '{2'd0, 3'd0, 4'h3, 16'h0000, 16'h0, 16'h0055, 4'd5}, // R5 stored
        '{2'd0, 3'd5, 4'h3, 16'h0066, 16'h0, 16'h0000, 4'd6}, // R6 reservation spent
        '{2'd0, 3'd0, 4'h3, 16'h0000, 16'h0, 16'h0055, 4'd6}, // R6 unchanged
        '{2'd1, 3'd4, 4'h7, 16'h0000, 16'h0, 16'h0000, 4'd5}, // R5 reserve a7
        '{2'd1, 3'd5, 4'h8, 16'h0001, 16'h0, 16'h0000, 4'd6}, // R6 address mismatch
        '{2'd2, 3'd1, 4'h7, 16'h0077, 16'h0, 16'h0000, 4'd7}, // R7 other writer hits a7
        '{2'd1, 3'd5, 4'h7, 16'h0002, 16'h0, 16'h0000, 4'd7}, // R7 store fails
        '{2'd1, 3'd0, 4'h7, 16'h0000, 16'h0, 16'h0077, 4'd7}, // R7 unchanged
        '{2'd2, 3'd4, 4'h9, 16'h0000, 16'h0, 16'h0000, 4'd7}, // R7 reserve a9
        '{2'd0, 3'd1, 4'hA, 16'h0005, 16'h0, 16'h0000, 4'd7}, // R7 write elsewhere
        '{2'd2, 3'd5, 4'h9, 16'h0003, 16'h0, 16'h0001, 4'd7}, // R7 reservation kept
        '{2'd0, 3'd4, 4'h5, 16'h0000, 16'h0, 16'h0007, 4'd7}, // R7 reserve a5
        '{2'd1, 3'd3, 4'h5, 16'h0001, 16'h0, 16'h0007, 4'd7}, // R7 exchange writes a5
        '{2'd0, 3'd5, 4'h5, 16'h0002, 16'h0, 16'h0000, 4'd7}, // R7 store fails
        '{2'd0, 3'd0, 4'h5, 16'h0000, 16'h0, 16'h0001, 4'd7}  // R7 exchanged value
    };

    // Grant-order log for the round-robin tests.
    bit log_en = 1'b0;
    int order [8];
    int n_log = 0;
    always @(negedge clk) begin
        #2;
        if (log_en && req_ready != '0) begin
            for (int i = 0; i < N; i++) if (req_ready[i] && n_log < 8) order[n_log] = i;
            n_log++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; v = '0; rr = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == '0 && resp_valid == '0, "R1 outputs idle in reset",
            DW'({req_ready, resp_valid}), 16'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [DW-1:0] r0, r1, r2;
        v = '0; rr = '0;
        for (int i = 0; i < N; i++) begin op_a[i] = '0; ad_a[i] = '0; wd_a[i] = '0; ar_a[i] = '0; end
        do_reset();
        @(negedge clk);
        chk(req_ready == '0 && resp_valid == '0, "R1 idle after reset",
            DW'({req_ready, resp_valid}), 16'h0);

        for (int k = 0; k < NV; k++) begin
            xact(int'(VECS[k].who), VECS[k].op, VECS[k].addr, VECS[k].wd, VECS[k].arg, 0, r0);
            total++;
            if (r0 !== VECS[k].exp) begin
                bad++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[k].rq, k, r0, VECS[k].exp);
            end
        end

        // R9: all three contend; the last grant went to 0, so order is 1, 2, 0.
        log_en = 1'b1; n_log = 0;
        fork
            xact(0, 3'd0, 4'h3, 16'h0, 16'h0, 0, r0);
            xact(1, 3'd0, 4'h6, 16'h0, 16'h0, 0, r1);
            xact(2, 3'd0, 4'h7, 16'h0, 16'h0, 0, r2);
        join
        chk(n_log == 3 && order[0] == 1 && order[1] == 2 && order[2] == 0,
            "R9 rotation 1,2,0", DW'(order[0]*16 + order[1]*4 + order[2]), 16'h0018);
        chk(r0 == 16'h0055 && r1 == 16'h00AA && r2 == 16'h0077, "R2 contended reads",
            r0 ^ r1 ^ r2, 16'h0055 ^ 16'h00AA ^ 16'h0077);

        // R9: 0 and 2 contend after 0 won; 2 goes first. Response held on 2 (R10, R8).
        n_log = 0;
        fork
            xact(0, 3'd0, 4'h6, 16'h0, 16'h0, 0, r0);
            xact(2, 3'd0, 4'h3, 16'h0, 16'h0, 3, r2);
        join
        chk(n_log == 2 && order[0] == 2 && order[1] == 0, "R9 rotation skip 2,0",
            DW'(order[0]*4 + order[1]), 16'h0008);
        chk(r2 == 16'h0055 && r0 == 16'h00AA, "R10 held data correct", r2, 16'h0055);
        log_en = 1'b0;

        // R1: reset in the middle of a reservation clears memory and the reservation.
        xact(0, 3'd1, 4'h2, 16'h0042, 16'h0, 0, r0);
        xact(0, 3'd4, 4'h2, 16'h0, 16'h0, 0, r0);
        chk(r0 == 16'h0042, "R5 reserve returns word", r0, 16'h0042);
        do_reset();
        xact(0, 3'd0, 4'h2, 16'h0, 16'h0, 0, r0);
        chk(r0 == 16'h0000, "R1 memory cleared by reset", r0, 16'h0000);
        xact(0, 3'd5, 4'h2, 16'h0099, 16'h0, 0, r0);
        chk(r0 == 16'h0000, "R1 reservation cleared by reset", r0, 16'h0000);
        xact(1, 3'd0, 4'h2, 16'h0, 16'h0, 0, r1);
        chk(r1 == 16'h0000, "R6 failed store left memory", r1, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule